// File: doc/BRIEF.md
# Multi-Mode Control Pin Decoder

This block turns one asynchronous, general-purpose control pin into the enable and select signals that a multi-synthesizer clock generator needs. A configuration input gives the pin one of four roles: frequency select, selective suspend, output enable or full power-down. The pin is first brought into the clock domain by a two-flop synchronizer. It is then decoded against programmed masks into per-synthesizer enables, per-output enables, a chip-wide power-down flag and a frequency-select level.

The block enforces one dependency rule: an output that takes its clock from a synthesizer that is turned off is turned off as well, even when the output's own suspend mask bit is clear. Whenever a synthesizer is switched back on, a relock timer counts a programmed number of cycles. During that count, every output fed by that synthesizer stays disabled and a lock-wait flag is raised. Outputs fed by the reference clock do not wait.

Top module: `ctlpin_decoder`

## Requirements
- R1: A change on `pin_in` reaches the registered outputs on the third rising clock edge after it is applied: two edges for the synchronizer and one for the output register.
- R2: `cfg_mode` encodes the pin role as follows: 0 = frequency select, 1 = suspend, 2 = output enable, 3 = power-down. In the three roles other than frequency select, the pin is active low.
- R3: In frequency-select mode, `freq_sel` follows the synchronized pin level, and every synthesizer and every output is enabled. In all other modes, `freq_sel` is 0.
- R4: In output-enable mode with the pin low, every bit of `out_en` is 0, every bit of `pll_en` is 1 and `pwr_down` is 0. Releasing the pin starts no relock wait.
- R5: In power-down mode with the pin low, `pll_en` and `out_en` are all 0 and `pwr_down` is 1.
- R6: In suspend mode with the pin low, `pll_en[p]` is the inverse of `cfg_pll_mask[p]`. An output whose bit in `cfg_out_mask` is set is disabled.
- R7: Each output `o` takes a source code from bits `[2*o+1:2*o]` of `cfg_out_src`: code 0 is the reference clock and code k (1 to 3) is synthesizer k-1. An output whose source synthesizer is disabled is also disabled, whatever its own mask bit says. Outputs on the reference clock are never disabled by this rule.
- R8: When `pll_en[p]` rises, outputs sourced from synthesizer p rise exactly L = `cfg_lock_cycles` clock edges later, and `lock_wait` is 1 during those L cycles. With L = 0 the outputs rise on the same edge.
- R9: A synchronous reset clears every output to 0 and presets the synchronizer to the high (idle) level. On the first edge after reset is released, the synthesizers switch on and the relock wait of R8 begins.
- R10: In suspend, output-enable and power-down modes, a high pin enables every synthesizer and every output, once any relock wait has finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 1 | Asynchronous control pin |
| cfg_mode | input | 2 | Pin role code |
| cfg_pll_mask | input | N_PLL | Synthesizers turned off by suspend |
| cfg_out_mask | input | N_OUT | Outputs turned off by suspend |
| cfg_out_src | input | N_OUT*SRC_W | Per-output source code (0 = reference, k = synthesizer k-1) |
| cfg_lock_cycles | input | LOCK_W | Relock wait length in cycles |
| pll_en | output | N_PLL | Synthesizer run enables |
| out_en | output | N_OUT | Output drive enables (0 = high impedance) |
| pwr_down | output | 1 | Chip-wide power-down flag |
| freq_sel | output | 1 | Frequency setting select (0 or 1) |
| lock_wait | output | 1 | A relock count is in progress |

## Verification
Two functions can act in the same cycle. One is the forced-dependency rule, which turns an output off because its source synthesizer is suspended. The other is the relock timer, which holds an output off after its synthesizer restarts. The bench provokes both together by suspending a synthesizer that feeds a masked-clear output and then releasing the pin with a nonzero lock count. It judges the result edge by edge: the synthesizer enable must rise on the third edge, while its dependent output must stay low for exactly the programmed count and then rise. Over the same window, a reference-fed output must stay high throughout.

// File: rtl/ctlpin_pkg.sv
package ctlpin_pkg;

  typedef enum logic [1:0] {
    MODE_FSEL = 2'd0,
    MODE_SUSP = 2'd1,
    MODE_OEN  = 2'd2,
    MODE_SHDN = 2'd3
  } pin_mode_e;

endpackage

// File: rtl/ctlpin_sync.sv
module ctlpin_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RST_VAL}};
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/ctlpin_mode_dec.sv
module ctlpin_mode_dec
  import ctlpin_pkg::*;
#(
  parameter int N_PLL = 3,
  parameter int N_OUT = 3,
  parameter int SRC_W = 2
) (
  input  pin_mode_e              mode,
  input  logic                   pin_lvl,
  input  logic [N_PLL-1:0]       pll_mask,
  input  logic [N_OUT-1:0]       out_mask,
  input  logic [N_OUT*SRC_W-1:0] out_src,
  output logic [N_PLL-1:0]       pll_req,
  output logic [N_OUT-1:0]       out_req,
  output logic                   pd_req,
  output logic                   fs_req
);
  logic             pin_low;
  logic [N_OUT-1:0] out_base;
  logic [N_OUT-1:0] dep_ok;

  assign pin_low = ~pin_lvl;

  always_comb begin
    pll_req  = '1;
    out_base = '1;
    pd_req   = 1'b0;
    fs_req   = 1'b0;
    unique case (mode)
      MODE_FSEL: fs_req = pin_lvl;
      MODE_SUSP: if (pin_low) begin
        pll_req  = ~pll_mask;
        out_base = ~out_mask;
      end
      MODE_OEN:  if (pin_low) out_base = '0;
      MODE_SHDN: if (pin_low) begin
        pll_req  = '0;
        out_base = '0;
        pd_req   = 1'b1;
      end
      default: ;
    endcase
  end

  for (genvar o = 0; o < N_OUT; o++) begin : g_dep
    always_comb begin
      dep_ok[o] = 1'b1;
      for (int p = 0; p < N_PLL; p++) begin
        if (out_src[o*SRC_W +: SRC_W] == SRC_W'(p + 1) && !pll_req[p])
          dep_ok[o] = 1'b0;
      end
    end
  end

  assign out_req = out_base & dep_ok;
endmodule

// File: rtl/ctlpin_relock.sv
module ctlpin_relock #(
  parameter int N_PLL  = 3,
  parameter int LOCK_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_PLL-1:0]  pll_req,
  input  logic [N_PLL-1:0]  pll_on_q,
  input  logic [LOCK_W-1:0] lock_cycles,
  output logic [N_PLL-1:0]  ready_nxt,
  output logic              busy_nxt
);
  logic [N_PLL-1:0] run_nxt;

  for (genvar p = 0; p < N_PLL; p++) begin : g_pll
    logic [LOCK_W-1:0] cnt;
    logic [LOCK_W-1:0] cnt_nxt;

    always_comb begin
      if (!pll_req[p])
        cnt_nxt = '0;
      else if (!pll_on_q[p])
        cnt_nxt = lock_cycles;
      else if (cnt != '0)
        cnt_nxt = cnt - 1'b1;
      else
        cnt_nxt = '0;
    end

    always_ff @(posedge clk) begin
      if (rst) cnt <= '0;
      else     cnt <= cnt_nxt;
    end

    assign run_nxt[p]   = (cnt_nxt != '0);
    assign ready_nxt[p] = pll_req[p] && (cnt_nxt == '0);
  end

  assign busy_nxt = |run_nxt;
endmodule

// File: rtl/ctlpin_decoder.sv
module ctlpin_decoder
  import ctlpin_pkg::*;
#(
  parameter int N_PLL  = 3,
  parameter int N_OUT  = 3,
  parameter int LOCK_W = 16,
  parameter int SYNC_N = 2,
  localparam int SRC_W = $clog2(N_PLL + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   pin_in,
  input  logic [1:0]             cfg_mode,
  input  logic [N_PLL-1:0]       cfg_pll_mask,
  input  logic [N_OUT-1:0]       cfg_out_mask,
  input  logic [N_OUT*SRC_W-1:0] cfg_out_src,
  input  logic [LOCK_W-1:0]      cfg_lock_cycles,
  output logic [N_PLL-1:0]       pll_en,
  output logic [N_OUT-1:0]       out_en,
  output logic                   pwr_down,
  output logic                   freq_sel,
  output logic                   lock_wait
);
  logic             pin_s;
  logic [N_PLL-1:0] pll_req;
  logic [N_OUT-1:0] out_req;
  logic             pd_req;
  logic             fs_req;
  logic [N_PLL-1:0] ready_nxt;
  logic             busy_nxt;
  logic [N_OUT-1:0] src_ok;
  pin_mode_e        mode;

  assign mode = pin_mode_e'(cfg_mode);

  ctlpin_sync #(.STAGES(SYNC_N), .RST_VAL(1'b1)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pin_in),
    .q   (pin_s)
  );

  ctlpin_mode_dec #(.N_PLL(N_PLL), .N_OUT(N_OUT), .SRC_W(SRC_W)) u_dec (
    .mode     (mode),
    .pin_lvl  (pin_s),
    .pll_mask (cfg_pll_mask),
    .out_mask (cfg_out_mask),
    .out_src  (cfg_out_src),
    .pll_req  (pll_req),
    .out_req  (out_req),
    .pd_req   (pd_req),
    .fs_req   (fs_req)
  );

  ctlpin_relock #(.N_PLL(N_PLL), .LOCK_W(LOCK_W)) u_relock (
    .clk         (clk),
    .rst         (rst),
    .pll_req     (pll_req),
    .pll_on_q    (pll_en),
    .lock_cycles (cfg_lock_cycles),
    .ready_nxt   (ready_nxt),
    .busy_nxt    (busy_nxt)
  );

  // An output fed by a synthesizer waits for that synthesizer's relock.
  for (genvar o = 0; o < N_OUT; o++) begin : g_gate
    always_comb begin
      src_ok[o] = 1'b1;
      for (int p = 0; p < N_PLL; p++) begin
        if (cfg_out_src[o*SRC_W +: SRC_W] == SRC_W'(p + 1))
          src_ok[o] = ready_nxt[p];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pll_en    <= '0;
      out_en    <= '0;
      pwr_down  <= 1'b0;
      freq_sel  <= 1'b0;
      lock_wait <= 1'b0;
    end else begin
      pll_en    <= pll_req;
      out_en    <= out_req & src_ok;
      pwr_down  <= pd_req;
      freq_sel  <= fs_req;
      lock_wait <= busy_nxt;
    end
  end
endmodule

// File: rtl/ctlpin_decoder_chk.sv
module ctlpin_decoder_chk
  import ctlpin_pkg::*;
#(
  parameter int N_PLL  = 3,
  parameter int N_OUT  = 3,
  parameter int LOCK_W = 16,
  localparam int SRC_W = $clog2(N_PLL + 1)
) (
  input logic                   clk,
  input logic                   rst,
  input logic [1:0]             cfg_mode,
  input logic [N_OUT*SRC_W-1:0] cfg_out_src,
  input logic [LOCK_W-1:0]      cfg_lock_cycles,
  input logic [N_PLL-1:0]       pll_en,
  input logic [N_OUT-1:0]       out_en,
  input logic                   pwr_down,
  input logic                   freq_sel,
  input logic                   lock_wait
);
  // R5: power-down leaves nothing running
  a_r5_pd_all_off: assert property (@(posedge clk) disable iff (rst)
    pwr_down |-> (pll_en == '0 && out_en == '0));

  // R3: the select level stays at setting 0 outside frequency-select mode
  a_r3_fsel_only: assert property (@(posedge clk) disable iff (rst)
    ($past(cfg_mode) != 2'(MODE_FSEL)) |-> !freq_sel);

  for (genvar p = 0; p < N_PLL; p++) begin : g_p
    // R8: a restarted synthesizer with a nonzero count raises the wait flag
    a_r8_wait_on_start: assert property (@(posedge clk) disable iff (rst)
      ($rose(pll_en[p]) && $past(cfg_lock_cycles) != '0) |-> lock_wait);

    for (genvar o = 0; o < N_OUT; o++) begin : g_o
      // R7: an enabled output never sits on a stopped synthesizer
      a_r7_dep_source_on: assert property (@(posedge clk) disable iff (rst)
        ($past(cfg_out_src[o*SRC_W +: SRC_W]) == SRC_W'(p + 1) && out_en[o])
          |-> pll_en[p]);

      // R8: a dependent output is still off on the edge its source restarts
      a_r8_hold_on_start: assert property (@(posedge clk) disable iff (rst)
        ($rose(pll_en[p]) && $past(cfg_lock_cycles) != '0 &&
         $past(cfg_out_src[o*SRC_W +: SRC_W]) == SRC_W'(p + 1)) |-> !out_en[o]);
    end
  end
endmodule

bind ctlpin_decoder ctlpin_decoder_chk #(
  .N_PLL(N_PLL), .N_OUT(N_OUT), .LOCK_W(LOCK_W)
) u_chk (
  .clk             (clk),
  .rst             (rst),
  .cfg_mode        (cfg_mode),
  .cfg_out_src     (cfg_out_src),
  .cfg_lock_cycles (cfg_lock_cycles),
  .pll_en          (pll_en),
  .out_en          (out_en),
  .pwr_down        (pwr_down),
  .freq_sel        (freq_sel),
  .lock_wait       (lock_wait)
);

// File: tb/ctlpin_decoder_bench.sv
`timescale 1ns/1ps
module ctlpin_decoder_bench;
  localparam int N_PLL  = 3;
  localparam int N_OUT  = 3;
  localparam int LOCK_W = 16;

  logic        clk = 1'b0;
  logic        rst;
  logic        pin_in;
  logic [1:0]  cfg_mode;
  logic [2:0]  cfg_pll_mask;
  logic [2:0]  cfg_out_mask;
  logic [5:0]  cfg_out_src;
  logic [15:0] cfg_lock_cycles;
  logic [2:0]  pll_en;
  logic [2:0]  out_en;
  logic        pwr_down;
  logic        freq_sel;
  logic        lock_wait;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  ctlpin_decoder #(.N_PLL(N_PLL), .N_OUT(N_OUT), .LOCK_W(LOCK_W)) u_ctlpin_decoder (
    .clk, .rst, .pin_in, .cfg_mode, .cfg_pll_mask, .cfg_out_mask,
    .cfg_out_src, .cfg_lock_cycles, .pll_en, .out_en, .pwr_down,
    .freq_sel, .lock_wait
  );

  // Source codes: out0 on synthesizer 0 (code 1), out1 on synthesizer 1
  // (code 2), out2 on the reference (code 0).
  localparam logic [5:0] SRC_STD = {2'd0, 2'd2, 2'd1};
  localparam logic [5:0] SRC_ALL3 = {2'd3, 2'd3, 2'd3};

  // {mode, pll_mask, out_mask, src, pin, exp_pll, exp_out, exp_pd, exp_fs}
  localparam int NV = 13;
  localparam logic [22:0] TBL [0:NV-1] = '{
    {2'd0, 3'b000, 3'b000, SRC_STD,  1'b1, 3'b111, 3'b111, 1'b0, 1'b1},
    {2'd0, 3'b000, 3'b000, SRC_STD,  1'b0, 3'b111, 3'b111, 1'b0, 1'b0},
    {2'd2, 3'b000, 3'b000, SRC_STD,  1'b0, 3'b111, 3'b000, 1'b0, 1'b0},
    {2'd2, 3'b000, 3'b000, SRC_STD,  1'b1, 3'b111, 3'b111, 1'b0, 1'b0},
    {2'd3, 3'b000, 3'b000, SRC_STD,  1'b0, 3'b000, 3'b000, 1'b1, 1'b0},
    {2'd3, 3'b000, 3'b000, SRC_STD,  1'b1, 3'b111, 3'b111, 1'b0, 1'b0},
    {2'd1, 3'b001, 3'b000, SRC_STD,  1'b0, 3'b110, 3'b110, 1'b0, 1'b0},
    {2'd1, 3'b000, 3'b100, SRC_STD,  1'b0, 3'b111, 3'b011, 1'b0, 1'b0},
    {2'd1, 3'b100, 3'b000, SRC_ALL3, 1'b0, 3'b011, 3'b000, 1'b0, 1'b0},
    {2'd1, 3'b100, 3'b000, SRC_ALL3, 1'b1, 3'b111, 3'b111, 1'b0, 1'b0},
    {2'd1, 3'b110, 3'b001, SRC_STD,  1'b0, 3'b001, 3'b100, 1'b0, 1'b0},
    {2'd1, 3'b111, 3'b000, SRC_STD,  1'b0, 3'b000, 3'b100, 1'b0, 1'b0},
    {2'd0, 3'b111, 3'b111, SRC_STD,  1'b0, 3'b111, 3'b111, 1'b0, 1'b0}
  };

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic wait_neg(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic string tag_of(input logic [1:0] m, input logic p);
    if (m == 2'd0)      return "R2 R3 freq-select";
    else if (p)         return "R2 R10 pin high";
    else if (m == 2'd1) return "R2 R6 R7 suspend";
    else if (m == 2'd2) return "R2 R4 output enable";
    else                return "R2 R5 power-down";
  endfunction

  initial begin
    rst = 1'b1; pin_in = 1'b1; cfg_mode = 2'd0;
    cfg_pll_mask = '0; cfg_out_mask = '0; cfg_out_src = SRC_STD;
    cfg_lock_cycles = '0;
    wait_neg(3);
    // R9: reset state
    chk("R9 reset pll_en", 8'(pll_en), 8'h0);
    chk("R9 reset out_en", 8'(out_en), 8'h0);
    chk("R9 reset flags", {4'h0, 1'b0, pwr_down, freq_sel, lock_wait}, 8'h0);
    rst = 1'b0;
    wait_neg(4);

    // Table walk, zero lock count
    for (int i = 0; i < NV; i++) begin
      logic [22:0] v;
      v = TBL[i];
      cfg_mode = v[22:21]; cfg_pll_mask = v[20:18]; cfg_out_mask = v[17:15];
      cfg_out_src = v[14:9]; pin_in = v[8];
      wait_neg(5);
      chk({tag_of(v[22:21], v[8]), " pll_en"}, 8'(pll_en), 8'(v[7:5]));
      chk({tag_of(v[22:21], v[8]), " out_en"}, 8'(out_en), 8'(v[4:2]));
      chk({tag_of(v[22:21], v[8]), " pd/fs"}, {6'h0, pwr_down, freq_sel}, {6'h0, v[1:0]});
    end

    // R1: synchronizer plus register latency in freq-select mode
    cfg_mode = 2'd0; cfg_pll_mask = '0; cfg_out_mask = '0; cfg_out_src = SRC_STD;
    pin_in = 1'b1; wait_neg(5);
    pin_in = 1'b0;
    wait_neg(2);
    chk("R1 fs before third edge", 8'(freq_sel), 8'h1);
    wait_neg(1);
    chk("R1 fs on third edge", 8'(freq_sel), 8'h0);

    // R8 with R7: suspended source, then release with a count of 4
    cfg_lock_cycles = 16'd4;
    cfg_mode = 2'd1; cfg_pll_mask = 3'b001; pin_in = 1'b0;
    wait_neg(8);
    chk("R7 dependent off while suspended", 8'(out_en), 8'b110);
    pin_in = 1'b1;
    wait_neg(3);
    chk("R8 pll on third edge", 8'(pll_en), 8'b111);
    chk("R8 dependent held", 8'(out_en), 8'b110);
    chk("R8 wait raised", 8'(lock_wait), 8'h1);
    wait_neg(3);
    chk("R8 dependent still held at L-1", 8'(out_en), 8'b110);
    wait_neg(1);
    chk("R8 dependent on at L", 8'(out_en), 8'b111);
    chk("R8 wait cleared at L", 8'(lock_wait), 8'h0);

    // R8: power-down release, reference output not held
    cfg_mode = 2'd3; pin_in = 1'b0;
    wait_neg(8);
    pin_in = 1'b1;
    wait_neg(3);
    chk("R8 ref output on at once", 8'(out_en), 8'b100);
    wait_neg(4);
    chk("R8 all on after wait", 8'(out_en), 8'b111);

    // R4: output-enable release starts no wait
    cfg_mode = 2'd2; pin_in = 1'b0;
    wait_neg(6);
    chk("R4 plls kept running", 8'(pll_en), 8'b111);
    pin_in = 1'b1;
    wait_neg(3);
    chk("R4 outputs back at once", 8'(out_en), 8'b111);
    chk("R4 no wait", 8'(lock_wait), 8'h0);

    // R9: reset in flight, then restart with wait
    cfg_mode = 2'd3; pin_in = 1'b1; rst = 1'b1;
    wait_neg(1);
    chk("R9 reset clears pll_en", 8'(pll_en), 8'h0);
    chk("R9 reset clears out_en", 8'(out_en), 8'h0);
    rst = 1'b0;
    wait_neg(1);
    chk("R9 plls on first edge", 8'(pll_en), 8'b111);
    chk("R9 wait after reset", 8'(lock_wait), 8'h1);
    wait_neg(3);
    chk("R9 dependents held", 8'(out_en), 8'b100);
    wait_neg(1);
    chk("R9 dependents on", 8'(out_en), 8'b111);

    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got=hung expected=done");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule